// File: doc/BRIEF.md
# Smart Card Receive Status Logic

This block is the receive half of an asynchronous half-duplex smart-card serial port. It synchronises the single I/O line and finds a start bit. It then samples eight data bits (least significant first) and one parity bit at the middle of each elementary time unit (ETU). The finished character is handed to a status stage that owns the receive data register and three flags: receive-full, overrun and parity-error.

The status stage drives two level interrupts, each gated by its own enable. One signals received data and the other signals a transfer error. A DMA request handshake moves only characters whose parity was clean. A character with bad parity still lands in the data register, so the host can read it, while the error interrupt reports it. The host clears a flag by reading the status first and then writing a clear for that flag. A DMA acknowledge clears the receive-full flag on its own. Dropping the receive enable puts the bit engine back to its initial state, which the controller uses before turning the line around for transmit.

Top module: `sc_rx_status`

## Requirements
- R1: After synchronous reset, all three flags, both interrupts, `dma_req` and `rx_data` are 0.
- R2: A frame is 1 low start bit, 8 data bits LSB first, 1 parity bit, then a high guard time, with every bit lasting `ETU` clocks and the line idling high. A clean frame loads `rx_data`, sets `full_flag` and leaves `par_flag` at 0.
- R3: A frame with bad parity is still loaded into `rx_data`, and it sets both `full_flag` and `par_flag`.
- R4: With `par_odd`=0 the data bits plus parity bit must hold an even count of ones. With `par_odd`=1 they must hold an odd count.
- R5: If a frame completes while `full_flag` is 1, `ovr_flag` sets and `rx_data` keeps its earlier value.
- R6: `rx_irq` is high exactly while `full_flag` and `rie` are both 1.
- R7: `err_irq` is high exactly while (`ovr_flag` or `par_flag`) and `eie` are both 1.
- R8: `dma_req` is high while `dma_en` is 1 and `full_flag` holds a character received with clean parity. It never rises for a character with a parity error.
- R9: A one-cycle `dma_ack` clears `full_flag`, and `dma_req` falls with it.
- R10: `host_clr` bit 0 clears full, bit 1 clears overrun and bit 2 clears parity error. A bit takes effect only if a `host_rd` pulse saw that flag at 1 since that bit's last clear. Without that read, the clear is ignored.
- R11: While `rx_en` is 0 the line is ignored. Dropping `rx_en` mid-frame abandons the partial character, and no flag changes.
- R12: A low pulse that has ended by the middle of the start bit is rejected as noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; 0 re-initialises the bit engine |
| line_i | input | 1 | Serial I/O line (asynchronous) |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| dma_en | input | 1 | DMA request enable |
| dma_ack | input | 1 | DMA read of the data register |
| host_rd | input | 1 | Host status read pulse (arms clears) |
| host_clr | input | 3 | Host clear pulse: bit0 full, bit1 overrun, bit2 parity |
| rx_data | output | 8 | Receive data register |
| full_flag | output | 1 | Receive data full |
| ovr_flag | output | 1 | Overrun |
| par_flag | output | 1 | Parity error |
| rx_irq | output | 1 | Receive interrupt request (level) |
| err_irq | output | 1 | Error interrupt request (level) |
| dma_req | output | 1 | DMA request for a clean character |

## Verification
The assertions assume that `dma_ack` is pulsed only while `dma_req` is high. They also assume that `host_rd` and `host_clr` never pulse in the same cycle and that the line holds each bit level for a full `ETU`. The directed stimulus drives every frame bit by bit at exactly `ETU` clocks and pulses the handshakes one cycle at a time on the falling edge. It acknowledges DMA only after seeing a request, and it separates each status read from its clear by a cycle.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_GUARD
  } rx_state_t;

  localparam int CLR_FULL = 0;
  localparam int CLR_OVR  = 1;
  localparam int CLR_PAR  = 2;
  localparam int NFLAGS   = 3;
endpackage

// File: rtl/sc_rx_bitcore.sv
module sc_rx_bitcore
  import sc_rx_pkg::*;
#(
  parameter int ETU = 372,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          line_i,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr
);
  localparam int CW   = $clog2(ETU + 1);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
  localparam int HALF = ETU / 2;

  logic [1:0]    sync_q;
  logic          ln;
  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;

  assign ln = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
    end else if (!en) begin
      state <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!ln) state <= S_START;
        end
        S_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (ln) state <= S_IDLE;
            else begin
              state <= S_DATA;
              bidx  <= '0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (cnt == CW'(ETU - 1)) begin
            cnt   <= '0;
            shreg <= {ln, shreg[DW-1:1]};
            if (bidx == BW'(DW - 1)) state <= S_PAR;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (cnt == CW'(ETU - 1)) begin
            cnt   <= '0;
            data  <= shreg;
            perr  <= ((^shreg) ^ ln) != par_odd;
            done  <= 1'b1;
            state <= S_GUARD;
          end else cnt <= cnt + 1'b1;
        end
        S_GUARD: begin
          if (cnt == CW'(ETU - 1)) begin
            cnt <= '0;
            if (ln) state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: no character is reported in the cycle after the enable is low
  p_no_done_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags
  import sc_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DW-1:0]     din,
  input  logic              perr,
  input  logic              rie,
  input  logic              eie,
  input  logic              dma_en,
  input  logic              dma_ack,
  input  logic              host_rd,
  input  logic [NFLAGS-1:0] host_clr,
  output logic [DW-1:0]     data,
  output logic              full,
  output logic              ovr,
  output logic              par,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              dma_req
);
  logic              good_q;
  logic [NFLAGS-1:0] armed_q;
  logic [NFLAGS-1:0] clr_eff;
  logic              full_eff;

  assign clr_eff  = host_clr & armed_q;
  assign full_eff = full & ~dma_ack & ~clr_eff[CLR_FULL];

  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      full    <= 1'b0;
      ovr     <= 1'b0;
      par     <= 1'b0;
      good_q  <= 1'b0;
      armed_q <= '0;
    end else begin
      if (host_rd)        armed_q <= {par, ovr, full};
      else if (|host_clr) armed_q <= armed_q & ~host_clr;

      full <= full_eff;
      ovr  <= ovr & ~clr_eff[CLR_OVR];
      par  <= par & ~clr_eff[CLR_PAR];

      if (done) begin
        if (full_eff) begin
          ovr <= 1'b1;
        end else begin
          data   <= din;
          full   <= 1'b1;
          good_q <= ~perr;
          if (perr) par <= 1'b1;
        end
      end
    end
  end

  assign rx_irq  = full & rie;
  assign err_irq = (ovr | par) & eie;
  assign dma_req = full & good_q & dma_en;

  // R5: overrun keeps the stored character
  p_ovr_keeps_data_r5: assert property (@(posedge clk) disable iff (rst)
    (done && full && !dma_ack && !(host_clr[CLR_FULL] && armed_q[CLR_FULL]))
      |=> (ovr && $stable(data)));

  // R3: an errored character is still stored with both flags set
  p_perr_loads_r3: assert property (@(posedge clk) disable iff (rst)
    (done && perr && !full) |=> (full && par && data == $past(din)));

  // R8: no DMA request for an errored character
  p_perr_no_dma_r8: assert property (@(posedge clk) disable iff (rst)
    (done && perr && !full) |=> !dma_req);

  // R9: acknowledge empties the register
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !done) |=> !full);

  // R10: an unarmed clear leaves the flag alone
  p_unarmed_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr && host_clr[CLR_OVR] && !armed_q[CLR_OVR]) |=> ovr);
endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status
  import sc_rx_pkg::*;
#(
  parameter int ETU = 372,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          line_i,
  input  logic          par_odd,
  input  logic          rie,
  input  logic          eie,
  input  logic          dma_en,
  input  logic          dma_ack,
  input  logic          host_rd,
  input  logic [2:0]    host_clr,
  output logic [DW-1:0] rx_data,
  output logic          full_flag,
  output logic          ovr_flag,
  output logic          par_flag,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);
  logic          c_done;
  logic [DW-1:0] c_data;
  logic          c_perr;

  sc_rx_bitcore #(.ETU(ETU), .DW(DW)) u_core (
    .clk(clk), .rst(rst), .en(rx_en), .line_i(line_i), .par_odd(par_odd),
    .done(c_done), .data(c_data), .perr(c_perr)
  );

  sc_rx_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .done(c_done), .din(c_data), .perr(c_perr),
    .rie(rie), .eie(eie), .dma_en(dma_en), .dma_ack(dma_ack),
    .host_rd(host_rd), .host_clr(host_clr),
    .data(rx_data), .full(full_flag), .ovr(ovr_flag), .par(par_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
  );

  // R6: receive interrupt only while data is held
  p_irq_needs_full_r6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> full_flag);

  // R8: a DMA request always refers to a held character
  p_dma_needs_full_r8: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> full_flag);
endmodule

// File: tb/sc_rx_status_bench.sv
module sc_rx_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ETU = 16;

  logic clk = 0, rst = 1;
  logic rx_en = 0, line_i = 1, par_odd = 0, rie = 0, eie = 0;
  logic dma_en = 0, dma_ack = 0, host_rd = 0;
  logic [2:0] host_clr = 0;
  logic [7:0] rx_data;
  logic full_flag, ovr_flag, par_flag, rx_irq, err_irq, dma_req;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_rx_status #(.ETU(ETU), .DW(8)) u_sc_rx_status (
    .clk(clk), .rst(rst), .rx_en(rx_en), .line_i(line_i), .par_odd(par_odd),
    .rie(rie), .eie(eie), .dma_en(dma_en), .dma_ack(dma_ack),
    .host_rd(host_rd), .host_clr(host_clr), .rx_data(rx_data),
    .full_flag(full_flag), .ovr_flag(ovr_flag), .par_flag(par_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic pbit);
    line_i = 0; hold(ETU);
    for (int i = 0; i < 8; i++) begin line_i = d[i]; hold(ETU); end
    line_i = pbit; hold(ETU);
    line_i = 1; hold(3 * ETU);
  endtask

  task automatic host_clear(logic [2:0] m);
    host_rd = 1; hold(1); host_rd = 0; hold(1);
    host_clr = m; hold(1); host_clr = 0; hold(1);
  endtask

  task automatic t_reset();
    check("R1 full", full_flag, 0);
    check("R1 ovr", ovr_flag, 0);
    check("R1 par", par_flag, 0);
    check("R1 irqs", {rx_irq, err_irq, dma_req}, 0);
    check("R1 data", rx_data, 0);
  endtask

  task automatic t_good();
    rie = 1;
    send(8'hA5, ^8'hA5);
    check("R2 data", rx_data, 8'hA5);
    check("R2 full", full_flag, 1);
    check("R2 par", par_flag, 0);
    check("R6 rx_irq on", rx_irq, 1);
    rie = 0; hold(1);
    check("R6 rx_irq masked", rx_irq, 0);
    rie = 1;
    host_clear(3'b001);
    check("R10 cleared after read", full_flag, 0);
    check("R6 rx_irq off", rx_irq, 0);
  endtask

  task automatic t_clr_noread();
    send(8'h3C, ^8'h3C);
    host_clr = 3'b001; hold(1); host_clr = 0; hold(1);
    check("R10 clear without read ignored", full_flag, 1);
    host_clear(3'b001);
    check("R10 clear after read", full_flag, 0);
  endtask

  task automatic t_parity_err();
    eie = 1;
    send(8'h01, 1'b0);
    check("R3 data kept", rx_data, 8'h01);
    check("R3 full", full_flag, 1);
    check("R3 par", par_flag, 1);
    check("R7 err_irq on", err_irq, 1);
    eie = 0; hold(1);
    check("R7 err_irq masked", err_irq, 0);
    host_clear(3'b101);
    check("R10 par cleared", par_flag, 0);
  endtask

  task automatic t_odd();
    par_odd = 1;
    send(8'h03, ~^8'h03);
    check("R4 odd ok data", rx_data, 8'h03);
    check("R4 odd ok par", par_flag, 0);
    host_clear(3'b001);
    send(8'h03, ^8'h03);
    check("R4 odd bad par", par_flag, 1);
    host_clear(3'b101);
    par_odd = 0;
  endtask

  task automatic t_overrun();
    eie = 1;
    send(8'h11, ^8'h11);
    send(8'h22, ^8'h22);
    check("R5 ovr", ovr_flag, 1);
    check("R5 data kept", rx_data, 8'h11);
    check("R7 err_irq ovr", err_irq, 1);
    host_clear(3'b011);
    check("R10 ovr cleared", ovr_flag, 0);
    eie = 0;
  endtask

  task automatic t_dma();
    dma_en = 1;
    send(8'h5A, ^8'h5A);
    check("R8 dma_req good", dma_req, 1);
    dma_ack = 1; hold(1); dma_ack = 0; hold(1);
    check("R9 full cleared", full_flag, 0);
    check("R9 dma_req drop", dma_req, 0);
    send(8'h07, ~^8'h07);
    check("R8 no dma for error", dma_req, 0);
    check("R8 errored byte held", full_flag, 1);
    host_clear(3'b101);
    dma_en = 0;
  endtask

  task automatic t_disable();
    rx_en = 0;
    send(8'h99, ^8'h99);
    check("R11 ignored when off", full_flag, 0);
    rx_en = 1;
    line_i = 0; hold(ETU);
    for (int i = 0; i < 3; i++) begin line_i = i[0]; hold(ETU); end
    rx_en = 0; line_i = 1; hold(2); rx_en = 1;
    hold(12 * ETU);
    check("R11 partial abandoned", full_flag, 0);
    send(8'hC3, ^8'hC3);
    check("R11 restart data", rx_data, 8'hC3);
    host_clear(3'b001);
  endtask

  task automatic t_false_start();
    line_i = 0; hold(ETU / 4); line_i = 1;
    hold(12 * ETU);
    check("R12 glitch rejected", full_flag, 0);
    check("R12 no parity flag", par_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    hold(3);
    rst = 0;
    hold(1);
    t_reset();
    rx_en = 1;
    hold(4);
    t_good();
    t_clr_noread();
    t_parity_err();
    t_odd();
    t_overrun();
    t_dma();
    t_disable();
    t_false_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule